// File: doc/BRIEF.md
# Global-History Pattern-Table Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of the most recent resolved branch outcomes. It also keeps a table of small saturating counters. The table is indexed by the history bits placed above a few low bits of the branch address. A fetch stage presents a branch address and gets back a taken or not-taken guess in the same cycle, with no register on the lookup path.

When a branch resolves, the execute stage presents its address and real outcome. On that clock edge the counter chosen by the pre-shift history and the resolved address moves one step toward the outcome. The outcome then enters the history. History changes only at resolution. There is no speculative history and no repair after a mispredict.

Top module: `bp_gas_predictor`

## Requirements
- R1: After reset the history is all zeros and every counter holds 01 (weakly not taken), so every address is predicted not taken until training.
- R2: The prediction is bit 1 of the counter at index {history[7:0], pred_pc[5:2]}. The history sits in index bits 11:4 and the address nibble in bits 3:0. The prediction is combinational and appears in the same cycle.
- R3: An update with upd_taken=1 raises the indexed counter by one. The counter stops at 11 and never wraps to 00.
- R4: An update with upd_taken=0 lowers the indexed counter by one. The counter stops at 00 and never wraps to 11.
- R5: Each update shifts the outcome into history bit 0 (1 = taken, 0 = not taken), moves the older bits up one place, and drops bit 7.
- R6: The counter index used by an update is built from the history as it was before that update's outcome is shifted in.
- R7: When a prediction and an update select the same counter in one cycle, the prediction shows the counter value from before the update.
- R8: While upd_valid is 0, upd_pc and upd_taken have no effect: no counter and no history bit changes.
- R9: Only pred_pc[5:2] and upd_pc[5:2] take part in indexing. Address bits 1:0 and bits above 5 are ignored.
- R10: A lone loop branch with a trip count of four (taken three times, then not taken) is predicted correctly on every execution once it has warmed up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | 32 | Address of the branch being fetched |
| pred_taken | output | 1 | Guessed direction for pred_pc, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The bench drives a counter to each end of its range through repeated same-direction updates. A design that wraps instead of saturating turns a strongly biased entry into the opposite guess. It also asks for a prediction in the same cycle as an update to the same entry, where a forwarding design would return the new value early. It holds upd_valid low while the other update inputs toggle, and it compares addresses that differ only outside bits 5:2. A design that shifts history on an idle cycle or hashes extra address bits would then land on an untrained counter. A four-trip loop and a vector walk are run against a behavioural model. Indexing with post-shift history, or shifting in the wrong bit order, makes them disagree.

// File: rtl/bp_pkg.sv
package bp_pkg;

   // Direction encoding carried on the history and outcome wires
   localparam logic DIR_NOT_TAKEN = 1'b0;
   localparam logic DIR_TAKEN     = 1'b1;

   // Reset value of a counter: one step below the taken threshold
   function automatic int unsigned weak_nt_value(input int unsigned ctr_w);
      return (1 << (ctr_w - 1)) - 1;
   endfunction

endpackage

// File: rtl/bp_ghr.sv
module bp_ghr #(
   parameter int HIST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   output logic [HIST_W-1:0] hist
);

   generate
      if (HIST_W < 2) begin : g_bad_width
         $error("bp_ghr: HIST_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist <= '0;
      end else if (shift_en) begin
         hist <= {hist[HIST_W-2:0], shift_bit};
      end
   end

   // R5
   ghr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (hist == {$past(hist[HIST_W-2:0]), $past(shift_bit)}));

   // R8
   ghr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(hist));

endmodule

// File: rtl/bp_index.sv
module bp_index #(
   parameter int PC_W      = 32,
   parameter int HIST_W    = 8,
   parameter int ADDR_BITS = 4,
   parameter int PC_LSB    = 2,
   localparam int IDX_W    = HIST_W + ADDR_BITS
) (
   input  logic [HIST_W-1:0] hist,
   input  logic [PC_W-1:0]   pc,
   output logic [IDX_W-1:0]  idx
);

   generate
      if (PC_LSB + ADDR_BITS > PC_W) begin : g_bad_slice
         $error("bp_index: address slice exceeds PC width");
      end
      if (ADDR_BITS == 0) begin : g_hist_only
         // Pure global-history indexing variant
         assign idx = hist;
      end else begin : g_hist_addr
         // History above the selected address bits
         assign idx = {hist, pc[PC_LSB +: ADDR_BITS]};
      end
   endgenerate

endmodule

// File: rtl/bp_ctr_step.sv
module bp_ctr_step #(
   parameter int CTR_W = 2
) (
   input  logic [CTR_W-1:0] cur,
   input  logic             up,
   output logic [CTR_W-1:0] nxt
);

   localparam logic [CTR_W-1:0] TOP = '1;
   localparam logic [CTR_W-1:0] BOT = '0;

   generate
      if (CTR_W < 1) begin : g_bad_ctr
         $error("bp_ctr_step: CTR_W must be positive");
      end
   endgenerate

   always_comb begin
      nxt = cur;
      if (up) begin
         if (cur != TOP) nxt = cur + CTR_W'(1);
      end else begin
         if (cur != BOT) nxt = cur - CTR_W'(1);
      end
   end

endmodule

// File: rtl/bp_pht.sv
module bp_pht #(
   parameter int IDX_W = 12,
   parameter int CTR_W = 2,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_dir,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up
);

   localparam logic [CTR_W-1:0] INIT = CTR_W'(bp_pkg::weak_nt_value(CTR_W));
   localparam logic [CTR_W-1:0] TOP  = '1;
   localparam logic [CTR_W-1:0] BOT  = '0;

   logic [CTR_W-1:0] tbl [DEPTH];
   logic [CTR_W-1:0] wr_cur;
   logic [CTR_W-1:0] wr_nxt;

   generate
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_depth
         $error("bp_pht: IDX_W out of supported range");
      end
   endgenerate

   assign rd_dir = tbl[rd_idx][CTR_W-1];
   assign wr_cur = tbl[wr_idx];

   bp_ctr_step #(.CTR_W(CTR_W)) u_step (
      .cur (wr_cur),
      .up  (wr_up),
      .nxt (wr_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) tbl[i] <= INIT;
      end else if (wr_en) begin
         tbl[wr_idx] <= wr_nxt;
      end
   end

   // Checker state: last write, for the counter-step properties
   logic             chk_v;
   logic             chk_up;
   logic [IDX_W-1:0] chk_idx;
   logic [CTR_W-1:0] chk_old;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_v   <= 1'b0;
         chk_up  <= 1'b0;
         chk_idx <= '0;
         chk_old <= '0;
      end else begin
         chk_v   <= wr_en;
         chk_up  <= wr_up;
         chk_idx <= wr_idx;
         chk_old <= wr_cur;
      end
   end

   // R3
   ctr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_v && chk_up) |->
         (tbl[chk_idx] == ((chk_old == TOP) ? TOP : CTR_W'(chk_old + CTR_W'(1)))));

   // R4
   ctr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_v && !chk_up) |->
         (tbl[chk_idx] == ((chk_old == BOT) ? BOT : CTR_W'(chk_old - CTR_W'(1)))));

endmodule

// File: rtl/bp_gas_predictor.sv
module bp_gas_predictor #(
   parameter int PC_W      = 32,
   parameter int HIST_W    = 8,
   parameter int ADDR_BITS = 4,
   parameter int PC_LSB    = 2,
   parameter int CTR_W     = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] pred_pc,
   output logic            pred_taken,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken
);

   localparam int IDX_W = HIST_W + ADDR_BITS;

   logic [HIST_W-1:0] hist;
   logic [IDX_W-1:0]  rd_idx;
   logic [IDX_W-1:0]  wr_idx;

   generate
      if (IDX_W > 16) begin : g_too_big
         $error("bp_gas_predictor: table index wider than 16 bits");
      end
   endgenerate

   bp_index #(
      .PC_W(PC_W), .HIST_W(HIST_W), .ADDR_BITS(ADDR_BITS), .PC_LSB(PC_LSB)
   ) u_rd_index (
      .hist (hist),
      .pc   (pred_pc),
      .idx  (rd_idx)
   );

   // Update index uses the history held before this outcome shifts in
   bp_index #(
      .PC_W(PC_W), .HIST_W(HIST_W), .ADDR_BITS(ADDR_BITS), .PC_LSB(PC_LSB)
   ) u_wr_index (
      .hist (hist),
      .pc   (upd_pc),
      .idx  (wr_idx)
   );

   bp_pht #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_pht (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (rd_idx),
      .rd_dir (pred_taken),
      .wr_en  (upd_valid),
      .wr_idx (wr_idx),
      .wr_up  (upd_taken)
   );

   bp_ghr #(.HIST_W(HIST_W)) u_ghr (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (upd_valid),
      .shift_bit (upd_taken),
      .hist      (hist)
   );

endmodule

// File: tb/bp_gas_predictor_test.sv
`timescale 1ns/1ps
module bp_gas_predictor_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pred_pc = '0;
   logic        pred_taken;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   bp_gas_predictor uut (
      .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
   );

   // Behavioural model
   logic [1:0] mdl [4096];
   logic [7:0] mh;

   function automatic logic [11:0] midx(input logic [7:0] h, input logic [31:0] pc);
      return {h, pc[5:2]};
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 4096; i++) mdl[i] = 2'b01;
      mh = '0;
   endtask

   task automatic model_update(input logic [31:0] pc, input logic tk);
      logic [11:0] i;
      i = midx(mh, pc);
      if (tk && mdl[i] != 2'b11) mdl[i] = mdl[i] + 2'b01;
      if (!tk && mdl[i] != 2'b00) mdl[i] = mdl[i] - 2'b01;
      mh = {mh[6:0], tk};
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: pred_taken=%b expected=%b", req, act, exp);
      end
   endtask

   // One cycle: present a prediction and (optionally) an update, check vs model
   task automatic step(input logic [31:0] ppc, input logic uv, input logic [31:0] upc,
                       input logic ut, input string req, output logic got);
      @(negedge clk);
      pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
      #1;
      got = pred_taken;
      check(req, got, mdl[midx(mh, ppc)][1]);
      @(posedge clk);
      if (uv) model_update(upc, ut);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; upd_valid = 1'b0;
      repeat (3) @(posedge clk);
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // {taken, pc}
   localparam logic [32:0] VEC [20] = '{
      {1'b1, 32'h0000_1000}, {1'b1, 32'h0000_1004}, {1'b0, 32'h8000_1008},
      {1'b1, 32'h0000_1000}, {1'b1, 32'h0040_103C}, {1'b0, 32'h0000_1004},
      {1'b1, 32'h0000_1000}, {1'b1, 32'h0000_1000}, {1'b0, 32'h1234_5673},
      {1'b1, 32'h0000_1004}, {1'b1, 32'h0000_1000}, {1'b1, 32'h0040_103C},
      {1'b0, 32'h0000_1000}, {1'b0, 32'h0000_1000}, {1'b0, 32'h0000_1000},
      {1'b1, 32'hFFFF_FFF0}, {1'b1, 32'h0000_1004}, {1'b0, 32'h8000_1008},
      {1'b1, 32'h0000_1000}, {1'b1, 32'h0000_1004}
   };

   localparam logic [31:0] PA = 32'h0000_4008;
   localparam logic [31:0] PB = PA ^ 32'hF0F0_0003;
   localparam logic [31:0] PD = 32'h0000_4010;
   localparam logic [31:0] PC = 32'h0000_4030;
   localparam logic [31:0] PL = 32'h0000_2010;

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic g;
      int miss;
      model_reset();

      // R1: reset state, several addresses predict not taken
      do_reset();
      step(PA, 0, PA, 0, "R1", g); check("R1", g, 1'b0);
      step(PC, 0, PA, 0, "R1", g); check("R1", g, 1'b0);
      step(32'hFFFF_FFFF, 0, PA, 0, "R1", g); check("R1", g, 1'b0);

      // R2/R6: vector walk, predict and update the same address each cycle
      foreach (VEC[k]) begin
         step(VEC[k][31:0], 1, VEC[k][31:0], VEC[k][32], "R2/R6", g);
      end

      // R1: reset after training clears counters and history
      do_reset();
      step(32'h0000_1000, 0, PA, 0, "R1", g); check("R1", g, 1'b0);

      // R3, R9: 12 taken updates saturate the counter at index {FF, A}
      do_reset();
      for (int k = 0; k < 12; k++) step(PA, 1, PA, 1, "R3", g);
      step(PA, 0, PA, 0, "R3", g); check("R3", g, 1'b1);
      step(PB, 0, PA, 0, "R9", g); check("R9", g, 1'b1);
      step(PD, 0, PA, 0, "R9", g); check("R9", g, 1'b0);

      // R4: three not-taken updates at history 00 stop the counter at 00
      do_reset();
      for (int k = 0; k < 3; k++) step(PA, 1, PA, 0, "R4", g);
      step(PA, 0, PA, 0, "R4", g); check("R4", g, 1'b0);

      // R7: same-cycle predict and update of one entry returns old value
      do_reset();
      step(PA, 1, PA, 1, "R7", g); check("R7", g, 1'b0);

      // R8: train {00,A} to 10, return history to 00, then idle updates
      do_reset();
      step(PA, 1, PA, 1, "R8", g);
      for (int k = 0; k < 8; k++) step(PC, 1, PC, 0, "R8", g);
      step(PA, 0, PA, 0, "R8", g); check("R8", g, 1'b1);
      for (int k = 0; k < 3; k++) begin
         step(PA, 0, PA, 0, "R8", g); check("R8", g, 1'b1);
      end
      for (int k = 0; k < 3; k++) begin
         step(PA, 0, PA, 1, "R8", g); check("R8", g, 1'b1);
      end
      // R5: one taken update shifts a 1 in, moving to untrained index {01,A}
      step(PC, 1, PC, 1, "R5", g);
      step(PA, 0, PA, 0, "R5", g); check("R5", g, 1'b0);

      // R10: four-trip loop, warm up then expect no mispredictions
      do_reset();
      for (int k = 0; k < 48; k++) step(PL, 1, PL, (k % 4) != 3, "R10", g);
      miss = 0;
      for (int k = 0; k < 40; k++) begin
         step(PL, 1, PL, (k % 4) != 3, "R10", g);
         if (g !== ((k % 4) != 3)) miss++;
      end
      total++;
      if (miss != 0) begin
         bad++;
         $display("FAIL R10: mispredicts=%0d expected=0", miss);
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule